// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block collects level-sensitive interrupt lines into banks of 32 and presents them to software over a small synchronous register bus. There is one bank, or two, chosen at build time. In each bank a source can be masked or unmasked, and software can read three views of that bank: the raw synchronized line levels, the mask, and the pending sources. A pending source is one that is high and not masked.

A single request line goes to the parent interrupt controller. It is high whenever any bank has a pending source. Mask bits never change through a read-modify-write. They change only through two write-only ports in each bank: one sets mask bits and the other clears them, and zero bits in the write data have no effect. Because the sources are level-sensitive, nothing needs to be acknowledged. A pending bit drops by itself when its line goes low.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every mask bit reads 1, every pending bit reads 0, every status bit reads 0 while the inputs are low, and `irq_o` is 0.
- R2: A write to bank offset 0x08 sets to 1 each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R3: A write to bank offset 0x0C clears to 0 each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R4: Bank offset 0x00 reads the level of that bank's 32 sources, taken through a two-flop synchronizer. An input change is visible at the status register two clock edges later.
- R5: Bank offset 0x10 reads status AND NOT mask for that bank. A pending bit falls by itself when its input goes low, and no write is needed to clear it.
- R6: `irq_o` is 1 exactly when at least one pending bit in any bank is 1. A high but masked source does not raise it.
- R7: Bank b occupies byte addresses b*0x20 to b*0x20+0x1F. Bit n of bank b's registers corresponds to `src_i[b*32+n]`.
- R8: Writes to offsets 0x00, 0x04 and 0x10, and writes to any unmapped address, leave every mask unchanged. Unmapped addresses read as 0. These are unused or unaligned offsets within a bank, and addresses at or above `NUM_BANKS*0x20`.
- R9: `bus_rdata` is registered. It takes the value at `bus_addr` on the clock edge where `bus_re` is 1, and holds its value while `bus_re` is 0.
- R10: Bank offset 0x04 reads that bank's current mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_i | input | NUM_BANKS*32 | Level-sensitive interrupt sources, asynchronous to `clk` |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; loads `bus_rdata` |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined request to the parent controller |

## Verification
Each mask bit in both banks is cleared and then set again with single-bit writes, one bit at a time. This shows that one write port touches only the bits it is given and that the two ports act in opposite directions. Multi-bit patterns are also written, and they show that zero data bits leave the other bits alone. A one-hot source walk across all 64 inputs, with every mask cleared, separates the bank mapping from the bit mapping. Bringing each source low again shows that its pending bit clears by itself. Mixed source and mask patterns, including all sources high with all masks set, show that pending and the combined output follow the AND with the inverted mask and not the raw levels.

// File: rtl/banked_irq_ctrl_pkg.sv
package banked_irq_ctrl_pkg;
  localparam int unsigned BANK_SRC   = 32;
  localparam int unsigned BANK_SHIFT = 5;   // 0x20 stride between banks
  localparam int unsigned OFS_W      = BANK_SHIFT;

  typedef enum logic [OFS_W-1:0] {
    OFS_LEVEL = 5'h00,
    OFS_MASK  = 5'h04,
    OFS_MSET  = 5'h08,
    OFS_MCLR  = 5'h0C,
    OFS_PEND  = 5'h10
  } reg_ofs_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  input  logic             set_en_i,
  input  logic             clr_en_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] mask_o,
  output logic [WIDTH-1:0] pend_o
);
  logic [WIDTH-1:0] mask_q;
  logic [WIDTH-1:0] mask_d;
  logic             mask_en;

  // Exactly one update port active loads the register; both active holds it.
  always_comb begin
    mask_en = set_en_i ^ clr_en_i;
    mask_d  = mask_q;
    if (set_en_i && !clr_en_i) begin
      mask_d = mask_q | wdata_i;
    end else if (clr_en_i && !set_en_i) begin
      mask_d = mask_q & ~wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
  assign pend_o = level_i & ~mask_q;
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import banked_irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_BANKS*BANK_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [31:0]                   bus_wdata,
  input  logic                          bus_we,
  input  logic                          bus_re,
  output logic [31:0]                   bus_rdata,
  output logic                          irq_o
);
  localparam int unsigned TOTAL = NUM_BANKS * BANK_SRC;
  localparam int unsigned SEL_W = ADDR_W - BANK_SHIFT;

  logic                 rst_core_n;
  logic [TOTAL-1:0]     status_all;
  logic [TOTAL-1:0]     mask_all;
  logic [TOTAL-1:0]     pend_all;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [NUM_BANKS-1:0] set_en;
  logic [NUM_BANKS-1:0] clr_en;
  logic [SEL_W-1:0]     bank_sel;
  logic [OFS_W-1:0]     reg_ofs;
  logic [31:0]          rdata_d;
  logic [31:0]          rdata_q;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  irq_sync2 #(.WIDTH(TOTAL)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   (src_i),
    .q_o   (status_all)
  );

  assign bank_sel = bus_addr[ADDR_W-1:BANK_SHIFT];
  assign reg_ofs  = bus_addr[OFS_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_hit[b] = (bank_sel == SEL_W'(b));
    assign set_en[b]   = bus_we && bank_hit[b] && (reg_ofs == OFS_MSET);
    assign clr_en[b]   = bus_we && bank_hit[b] && (reg_ofs == OFS_MCLR);

    irq_bank #(.WIDTH(BANK_SRC)) u_bank (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .level_i  (status_all[b*BANK_SRC +: BANK_SRC]),
      .set_en_i (set_en[b]),
      .clr_en_i (clr_en[b]),
      .wdata_i  (bus_wdata),
      .mask_o   (mask_all[b*BANK_SRC +: BANK_SRC]),
      .pend_o   (pend_all[b*BANK_SRC +: BANK_SRC])
    );
  end

  // Read select: unmapped banks and offsets fall through to zero.
  always_comb begin
    rdata_d = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) begin
        case (reg_ofs)
          OFS_LEVEL: rdata_d = status_all[b*BANK_SRC +: BANK_SRC];
          OFS_MASK:  rdata_d = mask_all[b*BANK_SRC +: BANK_SRC];
          OFS_PEND:  rdata_d = pend_all[b*BANK_SRC +: BANK_SRC];
          default:   rdata_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  rdata_q <= '0;
    else if (bus_re)  rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = |pend_all;
endmodule

// File: rtl/banked_irq_ctrl_chk.sv
module banked_irq_ctrl_chk #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_BANKS*32-1:0]  src_i,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [31:0]              bus_wdata,
  input logic                     bus_we,
  input logic                     bus_re,
  input logic [31:0]              bus_rdata,
  input logic                     irq_o,
  input logic [NUM_BANKS*32-1:0]  status_all,
  input logic [NUM_BANKS*32-1:0]  mask_all
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  AST_MASK_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(8)) |=> ((mask_all[31:0] & $past(bus_wdata)) == $past(bus_wdata))); // R2

  AST_MASK_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(12)) |=> ((mask_all[31:0] & $past(bus_wdata)) == 32'h0)); // R3

  AST_MASK_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(mask_all)); // R2

  AST_STATUS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (status_all == $past(src_i, 2))); // R4

  AST_IRQ_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == |(status_all & ~mask_all)); // R6

  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr[4:0] == 5'h00 || bus_addr[4:0] == 5'h04 || bus_addr[4:0] == 5'h10))
    |=> $stable(mask_all)); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata)); // R9
endmodule

bind banked_irq_ctrl banked_irq_ctrl_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .src_i      (src_i),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .bus_rdata  (bus_rdata),
  .irq_o      (irq_o),
  .status_all (status_all),
  .mask_all   (mask_all)
);

// File: tb/banked_irq_ctrl_test.sv
module banked_irq_ctrl_test;
  localparam int NB = 2;
  localparam int AW = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NB*32-1:0] src;
  logic [AW-1:0]  addr;
  logic [31:0]    wdata;
  logic           we;
  logic           re;
  logic [31:0]    rdata;
  logic           irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_mask [NB];
  logic [31:0] rd;
  logic [31:0] held;

  always #10 clk = ~clk;   // 50 MHz

  banked_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr),
    .bus_wdata(wdata), .bus_we(we), .bus_re(re), .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_pend(input int b);
    return src[b*32 +: 32] & ~exp_mask[b];
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int b = 0; b < NB; b++) r = r | (|exp_pend(b));
    return r;
  endfunction

  task automatic check_bank(input int b);
    bus_read(AW'(b*32 + 4), rd);  check("R10 mask", rd, exp_mask[b]);
    bus_read(AW'(b*32 + 0), rd);  check("R4 status", rd, src[b*32 +: 32]);
    bus_read(AW'(b*32 + 16), rd); check("R5 pending", rd, exp_pend(b));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src = '0; addr = '0; wdata = '0; we = 1'b0; re = 1'b0;
    for (int b = 0; b < NB; b++) exp_mask[b] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    for (int b = 0; b < NB; b++) begin
      bus_read(AW'(b*32 + 4), rd);  check("R1 mask", rd, 32'hFFFF_FFFF);
      bus_read(AW'(b*32 + 16), rd); check("R1 pending", rd, 32'h0);
      bus_read(AW'(b*32 + 0), rd);  check("R1 status", rd, 32'h0);
    end

    // R2/R3: single-bit clear then set sweep on every mask bit
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < 32; i++) begin
        bus_write(AW'(b*32 + 12), 32'd1 << i);
        exp_mask[b] = exp_mask[b] & ~(32'd1 << i);
        bus_read(AW'(b*32 + 4), rd); check("R3 clear bit", rd, exp_mask[b]);
        bus_write(AW'(b*32 + 8), 32'd1 << i);
        exp_mask[b] = exp_mask[b] | (32'd1 << i);
        bus_read(AW'(b*32 + 4), rd); check("R2 set bit", rd, exp_mask[b]);
      end
    end

    // R2/R3: multi-bit patterns, zero bits must not disturb others
    for (int k = 0; k < 12; k++) begin
      automatic int b = k % NB;
      automatic logic [31:0] v = 32'h9E37_79B9 * (k + 1);
      if (k % 3 == 2) begin
        bus_write(AW'(b*32 + 8), v);  exp_mask[b] = exp_mask[b] | v;
        bus_read(AW'(b*32 + 4), rd);  check("R2 pattern", rd, exp_mask[b]);
      end else begin
        bus_write(AW'(b*32 + 12), v); exp_mask[b] = exp_mask[b] & ~v;
        bus_read(AW'(b*32 + 4), rd);  check("R3 pattern", rd, exp_mask[b]);
      end
    end

    // R7/R4/R5/R6: one-hot source walk with all sources enabled
    for (int b = 0; b < NB; b++) begin
      bus_write(AW'(b*32 + 12), 32'hFFFF_FFFF); exp_mask[b] = '0;
    end
    for (int g = 0; g < NB*32; g++) begin
      src = '0; src[g] = 1'b1;
      settle();
      check("R6 irq walk", {31'd0, irq}, 32'd1);
      for (int b = 0; b < NB; b++) begin
        bus_read(AW'(b*32 + 0), rd);  check("R7 status map", rd, src[b*32 +: 32]);
        bus_read(AW'(b*32 + 16), rd); check("R7 pending map", rd, exp_pend(b));
      end
      src = '0;
      settle();
      check("R5 self clear irq", {31'd0, irq}, 32'd0);
      bus_read(AW'((g/32)*32 + 16), rd); check("R5 self clear", rd, 32'h0);
    end

    // R5/R6: all sources high with everything masked, then one enabled
    src = '1;
    for (int b = 0; b < NB; b++) begin
      bus_write(AW'(b*32 + 8), 32'hFFFF_FFFF); exp_mask[b] = '1;
    end
    settle();
    check("R6 all masked", {31'd0, irq}, 32'd0);
    bus_write(AW'((NB-1)*32 + 12), 32'h8000_0000);
    exp_mask[NB-1] = exp_mask[NB-1] & ~32'h8000_0000;
    check("R6 one enabled", {31'd0, irq}, 32'd1);
    check_bank(NB-1);

    // R5/R6: mixed source and mask patterns
    for (int k = 0; k < 8; k++) begin
      src = {32'h6A09_E667 * (k + 3), 32'hBB67_AE85 * (k + 5)};
      for (int b = 0; b < NB; b++) begin
        bus_write(AW'(b*32 + 8), 32'hFFFF_FFFF);
        bus_write(AW'(b*32 + 12), 32'h3C6E_F372 * (k + b + 1));
        exp_mask[b] = ~(32'h3C6E_F372 * (k + b + 1));
      end
      settle();
      for (int b = 0; b < NB; b++) check_bank(b);
      check("R6 mixed irq", {31'd0, irq}, {31'd0, exp_irq()});
    end

    // R8: writes to read-only and unmapped addresses
    bus_write(AW'(8'h00), 32'hFFFF_FFFF);
    bus_write(AW'(8'h04), 32'hFFFF_FFFF);
    bus_write(AW'(8'h10), 32'hFFFF_FFFF);
    bus_write(AW'(8'h24), 32'h0);
    bus_write(AW'(8'h14), 32'hFFFF_FFFF);
    bus_write(AW'(8'h09), 32'hFFFF_FFFF);
    bus_write(AW'(8'h2D), 32'hFFFF_FFFF);
    bus_write(AW'(8'h48), 32'hFFFF_FFFF);
    bus_write(AW'(8'h4C), 32'hFFFF_FFFF);
    bus_write(AW'(8'hE8), 32'hFFFF_FFFF);
    for (int b = 0; b < NB; b++) begin
      bus_read(AW'(b*32 + 4), rd); check("R8 mask untouched", rd, exp_mask[b]);
    end
    check("R8 irq untouched", {31'd0, irq}, {31'd0, exp_irq()});
    bus_read(AW'(8'h14), rd); check("R8 unmapped 0x14", rd, 32'h0);
    bus_read(AW'(8'h18), rd); check("R8 unmapped 0x18", rd, 32'h0);
    bus_read(AW'(8'h08), rd); check("R8 write-only 0x08", rd, 32'h0);
    bus_read(AW'(8'h2C), rd); check("R8 write-only 0x2C", rd, 32'h0);
    bus_read(AW'(8'h01), rd); check("R8 unaligned", rd, 32'h0);
    bus_read(AW'(8'h44), rd); check("R8 bank2", rd, 32'h0);
    bus_read(AW'(8'hF0), rd); check("R8 high addr", rd, 32'h0);

    // R9: read data holds while the read strobe is low
    bus_read(AW'(8'h04), held);
    check("R9 read", held, exp_mask[0]);
    bus_write(AW'(8'h0C), 32'hFFFF_FFFF); exp_mask[0] = '0;
    @(negedge clk); addr = AW'(8'h04);
    @(negedge clk);
    check("R9 hold", rdata, held);
    bus_read(AW'(8'h04), rd); check("R9 reload", rd, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule